// File: doc/BRIEF.md
# Data Effective Address Generator

This block forms the logical address used by load, store and cache-control operations. Each cycle that `in_valid` is high it accepts an addressing-mode code, the number of the base register field together with that register's value, the value of an index register and a signed immediate offset. One clock later it presents the resulting address with `out_valid`. Address relocation, the memory access itself, the register file and alignment checks all belong to other stages.

The base term is special: when the base register field number is zero, the base is the constant zero and the supplied register value is ignored. The index term is always taken as given. All arithmetic is unsigned and wraps at the address width. A reserved mode code still yields an address (the base term alone) but flags the result as illegal.

Top module: `data_ea_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `illegal_mode` are cleared at that edge and stay low until a request is accepted after reset is released.
- R2: Mode code 2'b00 (base only) gives `ea` equal to the base term.
- R3: Mode code 2'b01 (base plus immediate) gives `ea` equal to the base term plus the offset `imm` (bits 15:0).
- R4: Mode code 2'b10 (base plus index) gives `ea` equal to the base term plus `rb_val`, with `rb_val` never replaced by zero.
- R5: When `ra_idx` equals 0 the base term is 0 regardless of `ra_val`; otherwise it is `ra_val`.
- R6: Sums are unsigned modulo 2^32: any carry out of bit 31 is dropped (0xFFFFFFFF + 1 gives 0).
- R7: The 16-bit immediate is sign-extended from bit 15 before the addition, so 0xFFF0 adds -16 and 0x8000 adds -32768.
- R8: A request sampled with `in_valid` high at a rising edge appears on `ea` with `out_valid` high right after that edge; after an edge with `in_valid` low, `out_valid` is low and `ea` keeps its previous value.
- R9: Mode code 2'b11 is reserved: `ea` equals the base term and `illegal_mode` is high alongside `out_valid` for that result only; legal results carry `illegal_mode` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs are sampled when high |
| mode | input | 2 | Addressing mode code |
| ra_idx | input | 5 | Base register field number |
| ra_val | input | 32 | Contents of the base register |
| rb_val | input | 32 | Contents of the index register |
| imm | input | 16 | Signed immediate offset |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| ea | output | 32 | Effective address |
| illegal_mode | output | 1 | Result came from the reserved mode code |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit immediate and a 5-bit register field. These widths put the wrap past 0xFFFFFFFF, the sign boundary of the immediate at 0x7FFF/0x8000 and the zero-field substitution of the base directly within reach of hand-written vectors. Vectors are streamed back to back so that each result and its illegal flag are seen to belong to exactly one request, and idle cycles show the held address.

// File: rtl/ea_pkg.sv
// Package: ea_pkg
// Shared mode encoding for the effective-address generator.
// Assumes a two-bit mode field; the top code is reserved.
package ea_pkg;

    typedef enum logic [1:0] {
        EA_MODE_BASE     = 2'b00,
        EA_MODE_BASE_IMM = 2'b01,
        EA_MODE_BASE_IDX = 2'b10,
        EA_MODE_RSVD     = 2'b11
    } ea_mode_e;

endpackage

// File: rtl/ea_base_sel.sv
// Module: ea_base_sel
// Produces the base term of the address: zero when the register field
// number is zero, otherwise the supplied register value.
// Assumes ra_val is already read out of the register file for ra_idx.
module ea_base_sel #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [ADDR_W-1:0] ra_val,
    output logic [ADDR_W-1:0] base
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    // Substitute the constant zero for field number zero.
    always_comb begin
        if (ra_idx == ZERO_IDX) begin
            base = '0;
        end else begin
            base = ra_val;
        end
    end

endmodule

// File: rtl/ea_offset_sel.sv
// Module: ea_offset_sel
// Decodes the mode and picks the second addend: zero, the sign-extended
// immediate, or the index register value. Flags the reserved code.
// Assumes IMM_W <= ADDR_W.
module ea_offset_sel
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [1:0]        mode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] rb_val,
    output logic [ADDR_W-1:0] offset,
    output logic              illegal
);

    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_ext;
    ea_mode_e          mode_e;

    // Widen the immediate, replicating its sign bit when it is narrower.
    generate
        if (EXT_W > 0) begin : g_sext
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_same
            assign imm_ext = imm;
        end
    endgenerate

    assign mode_e = ea_mode_e'(mode);

    // Select the second addend and mark the reserved code.
    always_comb begin
        offset  = '0;
        illegal = 1'b0;
        case (mode_e)
            EA_MODE_BASE:     offset = '0;
            EA_MODE_BASE_IMM: offset = imm_ext;
            EA_MODE_BASE_IDX: offset = rb_val;
            default: begin
                offset  = '0;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ea_adder.sv
// Module: ea_adder
// Unsigned modular adder; the carry out of the top bit is discarded.
// Assumes both operands share the address width.
module ea_adder #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] a,
    input  logic [ADDR_W-1:0] b,
    output logic [ADDR_W-1:0] sum
);

    // Add at the address width so the result wraps.
    always_comb begin
        sum = a + b;
    end

endmodule

// File: rtl/data_ea_gen.sv
// Module: data_ea_gen
// Forms the effective address for data accesses from a base term and a
// mode-selected offset, registered through one stage with a valid strobe.
// Assumes register values are supplied alongside the request; synchronous
// active-low reset clears the strobes.
module data_ea_gen
    import ea_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [ADDR_W-1:0] ra_val,
    input  logic [ADDR_W-1:0] rb_val,
    input  logic [IMM_W-1:0]  imm,
    output logic              out_valid,
    output logic [ADDR_W-1:0] ea,
    output logic              illegal_mode
);

    localparam logic [IDX_W-1:0] ZERO_IDX = '0;

    logic [ADDR_W-1:0] base_term;
    logic [ADDR_W-1:0] offset_term;
    logic [ADDR_W-1:0] ea_next;
    logic              illegal_next;

    ea_base_sel #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_base (
        .ra_idx (ra_idx),
        .ra_val (ra_val),
        .base   (base_term)
    );

    ea_offset_sel #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_offset (
        .mode    (mode),
        .imm     (imm),
        .rb_val  (rb_val),
        .offset  (offset_term),
        .illegal (illegal_next)
    );

    ea_adder #(
        .ADDR_W (ADDR_W)
    ) u_add (
        .a   (base_term),
        .b   (offset_term),
        .sum (ea_next)
    );

    // Strobes: cleared by reset, follow the request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            illegal_mode <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            illegal_mode <= in_valid & illegal_next;
        end
    end

    // Address register: loads on an accepted request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea <= '0;
        end else if (in_valid) begin
            ea <= ea_next;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);  // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(ea)));  // R8

    AST_FLAG_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_mode |-> out_valid);  // R9

    AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == EA_MODE_RSVD) |=>
            (illegal_mode && ea == (($past(ra_idx) == ZERO_IDX) ? '0 : $past(ra_val))));  // R9

    AST_LEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode != EA_MODE_RSVD) |=> !illegal_mode);  // R9

    AST_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == EA_MODE_BASE && ra_idx == ZERO_IDX) |=> (ea == '0));  // R5

    AST_BASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == EA_MODE_BASE && ra_idx != ZERO_IDX) |=> (ea == $past(ra_val)));  // R2

    AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == EA_MODE_BASE_IDX && ra_idx != ZERO_IDX) |=>
            (ea == ADDR_W'($past(ra_val) + $past(rb_val))));  // R4

endmodule

// File: tb/data_ea_gen_tb.sv
module data_ea_gen_tb;

    typedef struct packed {
        logic [1:0]  m;
        logic [4:0]  ra;
        logic [31:0] rav;
        logic [31:0] rbv;
        logic [15:0] im;
        logic [31:0] exp_ea;
        logic        exp_ill;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 5'd3, 32'h1000_0040, 32'h0000_0005, 16'h0010, 32'h1000_0040, 1'b0, 8'd2}, // R2
        '{2'b01, 5'd3, 32'h1000_0040, 32'h0000_0005, 16'h0010, 32'h1000_0050, 1'b0, 8'd3}, // R3
        '{2'b01, 5'd4, 32'h0000_1000, 32'h0000_0000, 16'hFFF0, 32'h0000_0FF0, 1'b0, 8'd7}, // R7
        '{2'b10, 5'd7, 32'h1234_5678, 32'h1111_1111, 16'h0000, 32'h2345_6789, 1'b0, 8'd4}, // R4
        '{2'b10, 5'd0, 32'hDEAD_BEEF, 32'h0000_2000, 16'h0000, 32'h0000_2000, 1'b0, 8'd5}, // R5
        '{2'b00, 5'd0, 32'hDEAD_BEEF, 32'h0000_0000, 16'h1234, 32'h0000_0000, 1'b0, 8'd5}, // R5
        '{2'b10, 5'd1, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0000, 32'h0000_0000, 1'b0, 8'd6}, // R6
        '{2'b01, 5'd2, 32'hFFFF_FFF8, 32'h0000_0000, 16'h0010, 32'h0000_0008, 1'b0, 8'd6}, // R6
        '{2'b01, 5'd2, 32'h0000_0004, 32'h0000_0000, 16'h8000, 32'hFFFF_8004, 1'b0, 8'd7}, // R7
        '{2'b11, 5'd5, 32'hCAFE_F00D, 32'h0000_0009, 16'h0007, 32'hCAFE_F00D, 1'b1, 8'd9}, // R9
        '{2'b11, 5'd0, 32'hCAFE_F00D, 32'h0000_0009, 16'h0007, 32'h0000_0000, 1'b1, 8'd9}, // R9
        '{2'b10, 5'd6, 32'h8000_0000, 32'h8000_0000, 16'h0000, 32'h0000_0000, 1'b0, 8'd6}, // R6
        '{2'b01, 5'd0, 32'h0000_0055, 32'h0000_0000, 16'h7FFF, 32'h0000_7FFF, 1'b0, 8'd3}  // R3
    };

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  mode;
    logic [4:0]  ra_idx;
    logic [31:0] ra_val;
    logic [31:0] rb_val;
    logic [15:0] imm;
    logic        out_valid;
    logic [31:0] ea;
    logic        illegal_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    data_ea_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .mode         (mode),
        .ra_idx       (ra_idx),
        .ra_val       (ra_val),
        .rb_val       (rb_val),
        .imm          (imm),
        .out_valid    (out_valid),
        .ea           (ea),
        .illegal_mode (illegal_mode)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] m, input logic [4:0] ra,
                         input logic [31:0] rav, input logic [31:0] rbv, input logic [15:0] im);
        in_valid = v;
        mode     = m;
        ra_idx   = ra;
        ra_val   = rav;
        rb_val   = rbv;
        imm      = im;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 2'b00, 5'd0, 32'h0, 32'h0, 16'h0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid in reset", {31'b0, out_valid}, 32'h0);
        check("R1 illegal_mode in reset", {31'b0, illegal_mode}, 32'h0);

        // R1: a request presented during reset is not accepted
        drive(1'b1, 2'b11, 5'd1, 32'h1, 32'h0, 16'h0);
        @(negedge clk);
        check("R1 out_valid with request in reset", {31'b0, out_valid}, 32'h0);
        check("R1 illegal_mode with request in reset", {31'b0, illegal_mode}, 32'h0);
        drive(1'b0, 2'b00, 5'd0, 32'h0, 32'h0, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid idle after reset", {31'b0, out_valid}, 32'h0);

        // Vector table, streamed back to back
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].m, VECS[i].ra, VECS[i].rav, VECS[i].rbv, VECS[i].im);
            @(negedge clk);
            check($sformatf("R8 out_valid vec %0d (R%0d)", i, VECS[i].req), {31'b0, out_valid}, 32'h1);
            check($sformatf("R%0d ea vec %0d", VECS[i].req, i), ea, VECS[i].exp_ea);
            check($sformatf("R9 illegal_mode vec %0d", i), {31'b0, illegal_mode}, {31'b0, VECS[i].exp_ill});
        end

        // R8: idle cycle holds the last address, strobes low
        drive(1'b0, 2'b10, 5'd9, 32'h1111_1111, 32'h2222_2222, 16'h0);
        @(negedge clk);
        check("R8 out_valid idle", {31'b0, out_valid}, 32'h0);
        check("R8 ea held idle", ea, 32'h0000_7FFF);
        check("R9 illegal_mode idle", {31'b0, illegal_mode}, 32'h0);

        // R9: reserved result followed by an idle cycle clears the flag
        drive(1'b1, 2'b11, 5'd8, 32'h0000_ABCD, 32'h0, 16'h0);
        @(negedge clk);
        check("R9 illegal flag set", {31'b0, illegal_mode}, 32'h1);
        check("R9 reserved ea", ea, 32'h0000_ABCD);
        drive(1'b0, 2'b11, 5'd8, 32'h0, 32'h0, 16'h0);
        @(negedge clk);
        check("R9 illegal flag single result", {31'b0, illegal_mode}, 32'h0);
        check("R8 ea held after reserved", ea, 32'h0000_ABCD);

        // R4: index value zero is used as given
        drive(1'b1, 2'b10, 5'd3, 32'h0000_0100, 32'h0, 16'h0040);
        @(negedge clk);
        check("R4 zero index", ea, 32'h0000_0100);

        // R1: reset after activity clears strobes
        drive(1'b1, 2'b11, 5'd2, 32'h5, 32'h0, 16'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 out_valid cleared by reset", {31'b0, out_valid}, 32'h0);
        check("R1 illegal cleared by reset", {31'b0, illegal_mode}, 32'h0);
        drive(1'b0, 2'b00, 5'd0, 32'h0, 32'h0, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule